// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block moves incoming network frames into host memory through a circular list of receive descriptors that software prepares. Each descriptor is 8 bytes: a 32-bit buffer address at offset 0, then a 16-bit length at offset 4 and a 16-bit flags word at offset 6, all little-endian. With a 32-bit memory the second word therefore carries the length in bits 15:0 and the flags in bits 31:16. Software hands a buffer to the hardware by setting the availability flag and writing the buffer capacity minus one into the length field.

The block reads the current descriptor over a simple request/grant/response memory master. While that descriptor is available it accepts a byte stream and packs the bytes into 32-bit little-endian writes to the buffer. When every data write has been acknowledged it writes the descriptor back with the real frame size and a fixed completion pattern. It then raises a receive interrupt status bit and moves to the next ring entry. When no buffer is available, incoming frames are consumed and dropped, and a missed-frame counter records them. The same happens to frames that do not fit the buffer.

Top module: `rxd_ring_writer`

## Requirements
- R1: The current descriptor sits at `ring_base + 8*cur_idx`. The word at offset 0 is the buffer address, which is assumed to be 4-byte aligned. The word at offset 4 holds the length in bits 15:0 and the flags in bits 31:16.
- R2: `can_receive` is high only after the current descriptor has been read with the availability flag (flags bit 15, word bit 31) set. While that flag is clear, `can_receive` stays low and the descriptor is read again until the flag is set.
- R3: Byte n of an accepted frame is written to buffer address + n. It goes in byte lane n mod 4 of the word at buffer address + 4*(n div 4), with only the written lanes enabled in `mem_be`.
- R4: A frame longer than length+1 bytes writes no byte at offset length+1 or above. For such a frame the descriptor is not rewritten, `cur_idx` and `irq_rx` do not change, and `missed_cnt` increases by one.
- R5: After a frame that fits, the descriptor word at offset 4 is written once with all four byte enables set. Bits 15:0 carry the frame size in bytes (not minus one). Bits 31:16 carry exactly 0x2010: completion bit 13 and fixed bit 4, with the availability bit cleared.
- R6: The descriptor write-back request is issued only after every earlier memory request has received its response.
- R7: When the write-back response returns, `irq_rx` becomes 1 and `cur_idx` advances by one in the same cycle. `irq_rx` then stays 1 until an `irq_clr` pulse clears it.
- R8: After the entry at index `ring_last` has been completed, `cur_idx` returns to 0.
- R9: A frame that arrives while `can_receive` is low is consumed through `rx_ready` and produces no memory write. `missed_cnt` increases by one for each such frame.
- R10: A memory request, once raised, keeps `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` unchanged until `mem_gnt` is seen.
- R11: During reset, `cur_idx`, `irq_rx`, `missed_cnt`, `mem_req` and `can_receive` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | 32 | Byte address of ring entry 0 |
| ring_last | input | IDX_W | Index of the last ring entry |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the final one of its frame |
| rx_ready | output | 1 | Byte is consumed this cycle if valid |
| can_receive | output | 1 | Current descriptor is available; bytes will be stored |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rsp | input | 1 | One response, in request order |
| mem_rdata | input | 32 | Read data, valid with `mem_rsp` |
| irq_clr | input | 1 | Clears the receive interrupt status |
| irq_rx | output | 1 | Receive interrupt status |
| missed_cnt | output | CNT_W | Frames dropped |
| cur_idx | output | IDX_W | Current ring index |

## Verification
The bench sweeps frame sizes 1 to 12 and then 64 across a four-entry ring, so every lane alignment of the last partial word meets every ring slot, and the ring wraps three times. A packer with wrong byte enables would corrupt the guard bytes that follow the frame, and an off-by-one in the stored size would show in the written-back length. An off-by-one at the wrap would send a frame to a fifth, unarmed slot. A frame of exactly length+1 bytes and a frame three bytes too long probe the capacity edge: a design that compares against the raw length field either rejects the first or spills into the guard bytes on the second. The memory model delays grants and responses, so a write-back that races ahead of pending data writes is caught at the moment it is granted. A frame sent while no buffer is armed shows whether a design writes memory or fails to count the drop.

// File: rtl/rxd_pkg.sv
// Package: shared widths, controller states and the memory command record
// for the receive descriptor ring writer.
package rxd_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 16;            // descriptor length field
    localparam int CAP_W      = LEN_W + 1;     // capacity = length + 1
    localparam int BE_W       = DATA_W / 8;
    localparam int DESC_SHIFT = 3;             // 8-byte descriptors
    localparam int WORD1_OFF  = 4;             // length/flags word offset

    typedef enum logic [3:0] {
        ST_RD_ADDR,     // issue read of buffer-address word
        ST_RD_ADDR_W,   // wait for its response
        ST_RD_CTRL,     // issue read of length/flags word
        ST_RD_CTRL_W,   // wait for its response
        ST_RECV,        // buffer owned, store frame bytes
        ST_NOBUF,       // buffer not owned, decide poll or drop
        ST_DROP,        // consume rest of a frame without storing
        ST_DRAIN,       // wait for data writes, then write back
        ST_WB_W         // wait for write-back response
    } rxd_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } mem_cmd_t;

endpackage

// File: rtl/rxd_mem_port.sv
// Module: rxd_mem_port
// Holds one memory request until it is granted and counts requests that
// are still waiting for their response.
// Assumes responses arrive in request order, one per granted request, and
// never in the same cycle as the grant of that request.
module rxd_mem_port
    import rxd_pkg::*;
#(
    parameter int OUT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  mem_cmd_t          issue_cmd,
    output logic              issue_ready,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_gnt,
    input  logic              mem_rsp
);

    logic             pend_q;
    mem_cmd_t         cmd_q;
    logic [OUT_W-1:0] outs_q;
    logic             granted;

    assign granted     = pend_q && mem_gnt;
    assign issue_ready = !pend_q && (outs_q != {OUT_W{1'b1}});
    assign idle        = !pend_q && (outs_q == '0);

    assign mem_req   = pend_q;
    assign mem_we    = cmd_q.we;
    assign mem_addr  = cmd_q.addr;
    assign mem_wdata = cmd_q.data;
    assign mem_be    = cmd_q.be;

    // Capture a new command and hold it until the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cmd_q  <= '0;
        end else if (issue_valid && issue_ready) begin
            pend_q <= 1'b1;
            cmd_q  <= issue_cmd;
        end else if (granted) begin
            pend_q <= 1'b0;
        end
    end

    // Track granted requests whose response has not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outs_q <= '0;
        end else begin
            case ({granted, mem_rsp})
                2'b10:   outs_q <= outs_q + 1'b1;
                2'b01:   outs_q <= outs_q - 1'b1;
                default: outs_q <= outs_q;
            endcase
        end
    end

endmodule

// File: rtl/rxd_ring_ptr.sv
// Module: rxd_ring_ptr
// Keeps the current ring index and derives the descriptor byte address.
// Assumes ring_last stays constant while frames are in flight; an index
// at or above ring_last wraps to 0 on advance.
module rxd_ring_ptr
    import rxd_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_last,
    input  logic              advance,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [ADDR_W-1:0] desc_addr
);

    logic [ADDR_W-1:0] idx_ext;

    assign idx_ext   = ADDR_W'(cur_idx);
    assign desc_addr = ring_base + (idx_ext << DESC_SHIFT);

    // Step to the next entry, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
        end else if (advance) begin
            cur_idx <= (cur_idx >= ring_last) ? '0 : cur_idx + 1'b1;
        end
    end

endmodule

// File: rtl/rxd_byte_packer.sv
// Module: rxd_byte_packer
// Packs frame bytes into little-endian 32-bit words and enforces buffer
// capacity. A word is released when its top lane fills, when the frame
// ends, or when the last byte that fits has arrived. Bytes beyond the
// capacity are not stored and mark the frame as overflowed.
// Assumes take is never asserted while a released word cannot be issued.
module rxd_byte_packer
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic              last_in,
    input  logic [CAP_W-1:0]  cap,
    output logic              flush,
    output logic [DATA_W-1:0] word_data,
    output logic [BE_W-1:0]   word_be,
    output logic [ADDR_W-1:0] word_off,
    output logic [LEN_W-1:0]  frame_bytes,
    output logic              ovf_now
);

    logic [CAP_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_data_q;
    logic [BE_W-1:0]   acc_be_q;
    logic              ovf_q;
    logic [1:0]        lane;
    logic              in_cap;
    logic              at_cap_end;

    assign lane        = cnt_q[1:0];
    assign in_cap      = cnt_q < cap;
    assign at_cap_end  = (cnt_q == cap - 1'b1);
    assign flush       = take && in_cap && ((lane == 2'd3) || last_in || at_cap_end);
    assign word_off    = ADDR_W'({cnt_q[CAP_W-1:2], 2'b00});
    assign frame_bytes = cnt_q[LEN_W-1:0] + 1'b1;
    assign ovf_now     = ovf_q || (take && !in_cap);

    // Merge the incoming byte into its lane of the word being assembled.
    always_comb begin
        word_data = acc_data_q;
        word_be   = acc_be_q;
        if (in_cap) begin
            word_data[{lane, 3'b000} +: 8] = byte_in;
            word_be[lane]                  = 1'b1;
        end
    end

    // Advance the byte count and keep the partial word between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            acc_data_q <= '0;
            acc_be_q   <= '0;
            ovf_q      <= 1'b0;
        end else if (take && last_in) begin
            cnt_q      <= '0;
            acc_data_q <= '0;
            acc_be_q   <= '0;
            ovf_q      <= 1'b0;
        end else if (take) begin
            if (cnt_q != {CAP_W{1'b1}}) begin
                cnt_q <= cnt_q + 1'b1;
            end
            acc_data_q <= flush ? '0 : word_data;
            acc_be_q   <= flush ? '0 : word_be;
            ovf_q      <= ovf_now;
        end
    end

endmodule

// File: rtl/rxd_status.sv
// Module: rxd_status
// Receive interrupt status bit and dropped-frame counter.
// A set wins over a clear in the same cycle.
module rxd_status #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_irq,
    input  logic             irq_clr,
    input  logic             miss,
    output logic             irq_rx,
    output logic [CNT_W-1:0] missed_cnt
);

    // Sticky interrupt status, cleared by a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx <= 1'b0;
        end else if (set_irq) begin
            irq_rx <= 1'b1;
        end else if (irq_clr) begin
            irq_rx <= 1'b0;
        end
    end

    // Count one per dropped frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            missed_cnt <= '0;
        end else if (miss) begin
            missed_cnt <= missed_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rxd_ring_writer.sv
// Module: rxd_ring_writer (top)
// Receive descriptor ring DMA writer. Reads the current descriptor, stores
// a frame into its buffer when software owns it, writes the descriptor
// back with the frame size and a completion pattern after all data writes
// are acknowledged, then raises the interrupt status and advances.
// Frames that find no owned buffer, or do not fit, are consumed and counted.
// Assumes 4-byte aligned buffer addresses and in-order memory responses.
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int          IDX_W      = 8,
    parameter int          CNT_W      = 16,
    parameter int          OUT_W      = 3,
    parameter int          AVAIL_BIT  = 15,
    parameter logic [15:0] DONE_FLAGS = 16'h2010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ring_base,
    input  logic [IDX_W-1:0]  ring_last,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              can_receive,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_gnt,
    input  logic              mem_rsp,
    input  logic [31:0]       mem_rdata,
    input  logic              irq_clr,
    output logic              irq_rx,
    output logic [CNT_W-1:0]  missed_cnt,
    output logic [IDX_W-1:0]  cur_idx
);

    rxd_state_e        state_q, state_d;
    logic [ADDR_W-1:0] buf_addr_q;
    logic [CAP_W-1:0]  cap_q;
    logic [LEN_W-1:0]  frm_len_q;

    logic [ADDR_W-1:0] desc_addr;
    logic              advance;
    logic              set_irq;
    logic              miss;

    logic              port_ready;
    logic              port_idle;
    logic              issue_valid;
    mem_cmd_t          issue_cmd;
    logic              issued;

    logic              take;
    logic              drop_take;
    logic              pk_flush;
    logic [DATA_W-1:0] pk_data;
    logic [BE_W-1:0]   pk_be;
    logic [ADDR_W-1:0] pk_off;
    logic [LEN_W-1:0]  pk_bytes;
    logic              pk_ovf;
    logic [15:0]       rd_flags;

    assign can_receive = (state_q == ST_RECV);
    assign rx_ready    = (can_receive && port_ready)
                       || (state_q == ST_NOBUF) || (state_q == ST_DROP);
    assign take        = rx_valid && rx_ready && can_receive;
    assign drop_take   = rx_valid && rx_ready && !can_receive;
    assign issued      = issue_valid && port_ready;
    assign rd_flags    = mem_rdata[31:16];

    assign advance = (state_q == ST_WB_W) && port_idle;
    assign set_irq = advance;
    assign miss    = (take && rx_last && pk_ovf) || (drop_take && rx_last);

    rxd_ring_ptr #(
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .ring_last (ring_last),
        .advance   (advance),
        .cur_idx   (cur_idx),
        .desc_addr (desc_addr)
    );

    rxd_byte_packer u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .byte_in     (rx_data),
        .last_in     (rx_last),
        .cap         (cap_q),
        .flush       (pk_flush),
        .word_data   (pk_data),
        .word_be     (pk_be),
        .word_off    (pk_off),
        .frame_bytes (pk_bytes),
        .ovf_now     (pk_ovf)
    );

    rxd_mem_port #(
        .OUT_W (OUT_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_cmd   (issue_cmd),
        .issue_ready (port_ready),
        .idle        (port_idle),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_be      (mem_be),
        .mem_gnt     (mem_gnt),
        .mem_rsp     (mem_rsp)
    );

    rxd_status #(
        .CNT_W (CNT_W)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_irq    (set_irq),
        .irq_clr    (irq_clr),
        .miss       (miss),
        .irq_rx     (irq_rx),
        .missed_cnt (missed_cnt)
    );

    // Select the memory command the current state wants to issue.
    always_comb begin
        issue_valid = 1'b0;
        issue_cmd   = '0;
        case (state_q)
            ST_RD_ADDR: begin
                issue_valid    = 1'b1;
                issue_cmd.addr = desc_addr;
            end
            ST_RD_CTRL: begin
                issue_valid    = 1'b1;
                issue_cmd.addr = desc_addr + ADDR_W'(WORD1_OFF);
            end
            ST_RECV: begin
                issue_valid    = take && pk_flush;
                issue_cmd.we   = 1'b1;
                issue_cmd.addr = buf_addr_q + pk_off;
                issue_cmd.data = pk_data;
                issue_cmd.be   = pk_be;
            end
            ST_DRAIN: begin
                issue_valid    = port_idle;
                issue_cmd.we   = 1'b1;
                issue_cmd.addr = desc_addr + ADDR_W'(WORD1_OFF);
                issue_cmd.data = {DONE_FLAGS, frm_len_q};
                issue_cmd.be   = {BE_W{1'b1}};
            end
            default: begin
                issue_valid = 1'b0;
            end
        endcase
    end

    // Next-state decision of the descriptor controller.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RD_ADDR:   if (issued)  state_d = ST_RD_ADDR_W;
            ST_RD_ADDR_W: if (mem_rsp) state_d = ST_RD_CTRL;
            ST_RD_CTRL:   if (issued)  state_d = ST_RD_CTRL_W;
            ST_RD_CTRL_W: begin
                if (mem_rsp) begin
                    state_d = rd_flags[AVAIL_BIT] ? ST_RECV : ST_NOBUF;
                end
            end
            ST_RECV: begin
                if (take && rx_last && !pk_ovf) state_d = ST_DRAIN;
            end
            ST_NOBUF: begin
                if (!rx_valid)        state_d = ST_RD_ADDR;
                else if (rx_last)     state_d = ST_RD_ADDR;
                else                  state_d = ST_DROP;
            end
            ST_DROP:  if (drop_take && rx_last) state_d = ST_RD_ADDR;
            ST_DRAIN: if (issued)               state_d = ST_WB_W;
            ST_WB_W:  if (port_idle)            state_d = ST_RD_ADDR;
            default:                            state_d = ST_RD_ADDR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RD_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch descriptor fields as they return and the size of a good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr_q <= '0;
            cap_q      <= '0;
            frm_len_q  <= '0;
        end else begin
            if (state_q == ST_RD_ADDR_W && mem_rsp) begin
                buf_addr_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
            end
            if (state_q == ST_RD_CTRL_W && mem_rsp) begin
                cap_q <= {1'b0, mem_rdata[LEN_W-1:0]} + 1'b1;
            end
            if (take && rx_last) begin
                frm_len_q <= pk_bytes;
            end
        end
    end

endmodule

// File: rtl/rxd_ring_writer_chk.sv
// Module: rxd_ring_writer_chk
// Property checker bound to rxd_ring_writer. Keeps its own count of
// granted requests without responses, taken from the memory ports.
module rxd_ring_writer_chk #(
    parameter int          IDX_W      = 8,
    parameter int          CNT_W      = 16,
    parameter logic [15:0] DONE_FLAGS = 16'h2010
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      ring_base,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic [3:0]       mem_be,
    input logic             mem_gnt,
    input logic             mem_rsp,
    input logic             can_receive,
    input logic             irq_rx,
    input logic [CNT_W-1:0] missed_cnt,
    input logic [IDX_W-1:0] cur_idx
);

    logic [7:0]  outs_q;
    logic        req_d;
    logic [31:0] wb_addr;
    logic        is_wb;
    logic        new_req;

    assign wb_addr = ring_base + (32'(cur_idx) << 3) + 32'd4;
    assign is_wb   = mem_req && mem_we && (mem_addr == wb_addr);
    assign new_req = mem_req && !req_d;

    // Outstanding request count seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outs_q <= '0;
            req_d  <= 1'b0;
        end else begin
            req_d <= mem_req;
            case ({mem_req && mem_gnt, mem_rsp})
                2'b10:   outs_q <= outs_q + 1'b1;
                2'b01:   outs_q <= outs_q - 1'b1;
                default: outs_q <= outs_q;
            endcase
        end
    end

    // R11
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_quiet_chk: assert (!mem_req && !can_receive)
                else $error("request or receive during reset");
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                && $stable(mem_we) && $stable(mem_be));

    // R6
    wb_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_req && is_wb |-> outs_q == 8'd0);

    // R5
    wb_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wb |-> mem_wdata[31:16] == DONE_FLAGS && mem_be == 4'hF);

    // R3
    write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'h0);

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_idx) |-> cur_idx == '0 || cur_idx == $past(cur_idx) + 1'b1);

    // R7
    idx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_idx) |-> irq_rx);

    // R9
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(missed_cnt) |-> missed_cnt == $past(missed_cnt) + 1'b1);

endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .DONE_FLAGS (DONE_FLAGS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_base   (ring_base),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .mem_gnt     (mem_gnt),
    .mem_rsp     (mem_rsp),
    .can_receive (can_receive),
    .irq_rx      (irq_rx),
    .missed_cnt  (missed_cnt),
    .cur_idx     (cur_idx)
);

// File: tb/rxd_ring_writer_tb.sv
`timescale 1ns/1ps
module rxd_ring_writer_tb;

    localparam int IDX_W = 8;
    localparam int CNT_W = 16;
    localparam int NDESC = 4;
    localparam logic [31:0] BASE = 32'h100;
    localparam logic [31:0] BUF0 = 32'h200;
    localparam int BUFSZ = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_last = 1'b0, irq_clr = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_ready, can_receive, mem_req, mem_we, mem_gnt, mem_rsp, irq_rx;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic [CNT_W-1:0] missed_cnt;
    logic [IDX_W-1:0] cur_idx;

    int total = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxd_ring_writer #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE), .ring_last(8'(NDESC - 1)),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .can_receive(can_receive), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_gnt(mem_gnt), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
        .irq_clr(irq_clr), .irq_rx(irq_rx), .missed_cnt(missed_cnt), .cur_idx(cur_idx));

    // ---------------- memory model: stalls grants, 2-cycle in-order responses
    logic [31:0] mem [256];
    logic [7:0]  stall_cnt = 8'd0;
    logic [1:0]  rsp_pipe = 2'b00;
    logic [31:0] rd0 = '0, rd1 = '0;

    assign mem_gnt   = mem_req && (stall_cnt[1:0] != 2'b11);
    assign mem_rsp   = rsp_pipe[1];
    assign mem_rdata = rd1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 8'd1;
        rd1 <= rd0;
        if (!rst_n) begin
            rsp_pipe <= 2'b00;
        end else begin
            rsp_pipe <= {rsp_pipe[0], mem_req && mem_gnt};
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    if (mem_addr >= BASE && mem_addr < BASE + 32'(8 * NDESC) && mem_addr[2])
                        chk(rsp_pipe == 2'b00, "R6 write-back with responses pending",
                            32'(rsp_pipe), 32'h0);
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end else begin
                    rd0 <= mem[mem_addr[9:2]];
                end
            end
        end
    end

    // ---------------- helpers
    function automatic logic [7:0] exp_byte(input int id, input int n);
        return 8'(id * 37 + n * 5 + 3);
    endfunction

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[a[9:2]][8 * a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] buf_addr(input int i);
        return BUF0 + 32'(i * BUFSZ);
    endfunction

    task automatic set_ctrl(input int i, input logic [31:0] w);
        mem[(BASE[9:2]) + 8'(2 * i + 1)] = w;
    endtask

    function automatic logic [31:0] get_ctrl(input int i);
        return mem[(BASE[9:2]) + 8'(2 * i + 1)];
    endfunction

    task automatic fill_buf(input int i);
        for (int w = 0; w < BUFSZ / 4; w++) mem[buf_addr(i)[9:2] + 8'(w)] = 32'hA5A5A5A5;
    endtask

    task automatic send_frame(input int id, input int len);
        for (int n = 0; n < len; n++) begin
            rx_valid = 1'b1;
            rx_data  = exp_byte(id, n);
            rx_last  = (n == len - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_irq();
        for (int t = 0; t < 600 && !irq_rx; t++) @(negedge clk);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Check stored bytes 0..upto-1 and guard bytes from upto to guard_end-1.
    task automatic chk_buf(input int i, input int id, input int upto, input int guard_end,
                           input string req);
        bit ok = 1'b1;
        logic [31:0] act = '0, exp = '0;
        for (int n = 0; n < guard_end && n < BUFSZ; n++) begin
            logic [7:0] e;
            e = (n < upto) ? exp_byte(id, n) : 8'hA5;
            if (ok && rd_byte(buf_addr(i) + 32'(n)) !== e) begin
                ok  = 1'b0;
                act = {16'(n), 8'h0, rd_byte(buf_addr(i) + 32'(n))};
                exp = {16'(n), 8'h0, e};
            end
        end
        chk(ok, req, act, exp);
    endtask

    // ---------------- watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // ---------------- main sequence
    initial begin
        int exp_idx;
        for (int w = 0; w < 256; w++) mem[w] = 32'hA5A5A5A5;
        for (int i = 0; i < NDESC; i++) begin
            mem[BASE[9:2] + 8'(2 * i)] = buf_addr(i);
            set_ctrl(i, 32'h0);
        end

        repeat (5) @(negedge clk);
        // R11 reset state
        chk(cur_idx == 0, "R11 cur_idx in reset", 32'(cur_idx), 0);
        chk(irq_rx == 0 && missed_cnt == 0, "R11 irq/missed in reset",
            {irq_rx, 15'h0, missed_cnt}, 0);
        chk(!mem_req && !can_receive, "R11 req/can_receive in reset",
            {mem_req, can_receive}, 0);
        rst_n = 1'b1;

        // R2 no owned buffer: no receive
        repeat (40) @(negedge clk);
        chk(can_receive == 0, "R2 can_receive with AVAIL clear", 32'(can_receive), 0);

        // R9 frame while no buffer is owned
        send_frame(0, 5);
        repeat (20) @(negedge clk);
        chk(missed_cnt == 1, "R9 missed count after drop", 32'(missed_cnt), 1);
        chk_buf(0, 0, 0, 8, "R9 dropped frame wrote buffer");
        chk(cur_idx == 0 && !irq_rx, "R9 index/irq after drop", {irq_rx, 23'h0, cur_idx}, 0);

        // R4 oversize: capacity 6, frame 9
        set_ctrl(0, 32'h8000_0005);
        for (int t = 0; t < 60 && !can_receive; t++) @(negedge clk);
        chk(can_receive == 1, "R2 can_receive with AVAIL set", 32'(can_receive), 1);
        send_frame(1, 9);
        repeat (30) @(negedge clk);
        chk(missed_cnt == 2, "R4 oversize counted", 32'(missed_cnt), 2);
        chk(get_ctrl(0) == 32'h8000_0005, "R4 descriptor untouched", get_ctrl(0), 32'h8000_0005);
        chk(cur_idx == 0 && !irq_rx, "R4 index/irq unchanged", {irq_rx, 23'h0, cur_idx}, 0);
        chk_buf(0, 1, 6, 12, "R4 bytes beyond capacity");

        // R5 exact capacity frame of 6 bytes into the same descriptor
        for (int i = 1; i < NDESC; i++) set_ctrl(i, 32'h8000_003F);
        fill_buf(0);
        send_frame(2, 6);
        wait_irq();
        chk(get_ctrl(0) == 32'h2010_0006, "R5 R1 write-back at capacity", get_ctrl(0),
            32'h2010_0006);
        chk_buf(0, 2, 6, 8, "R3 capacity frame data");
        chk(cur_idx == 1 && irq_rx, "R7 advance with irq", {irq_rx, 23'h0, cur_idx},
            {1'b1, 23'h0, 8'd1});
        repeat (3) @(negedge clk);
        chk(irq_rx == 1, "R7 irq held", 32'(irq_rx), 1);
        clear_irq();
        chk(irq_rx == 0, "R7 irq cleared", 32'(irq_rx), 0);
        set_ctrl(0, 32'h8000_003F);

        // R3 R5 R8 sweep of sizes across the ring, wrapping three times
        exp_idx = 1;
        for (int f = 0; f < 13; f++) begin
            int len;
            len = (f < 12) ? f + 1 : BUFSZ;
            fill_buf(exp_idx);
            send_frame(10 + f, len);
            wait_irq();
            chk(get_ctrl(exp_idx) == {16'h2010, 16'(len)}, "R5 R1 write-back size/flags",
                get_ctrl(exp_idx), {16'h2010, 16'(len)});
            chk_buf(exp_idx, 10 + f, len, len + 4, "R3 frame bytes and lanes");
            chk(32'(cur_idx) == 32'((exp_idx + 1) % NDESC), "R8 R7 index after frame",
                32'(cur_idx), 32'((exp_idx + 1) % NDESC));
            clear_irq();
            set_ctrl(exp_idx, 32'h8000_003F);
            exp_idx = (exp_idx + 1) % NDESC;
        end
        chk(missed_cnt == 2, "R9 no drops while buffers owned", 32'(missed_cnt), 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule